// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers level-sensitive interrupt requests from a set of on-chip peripheral sources and from a 4-bit encoded external level input, and offers the CPU one request at a time: the most urgent unmasked one, with its exception code and priority level. Each peripheral source takes its priority from a 4-bit field held in a small register file. Several sources may be tied to the same field, so that a whole group, such as all the events of one serial port, is raised or lowered with one write.

Software programs the block over a simple word bus. Four narrow priority registers carry four fields each. One wide priority register carries fields in its upper half only. A 32-bit mask is changed through two addresses, one that sets bits and one that clears them, so neither change needs a read-modify-write. The external input has 15 active levels, each with a fixed priority and a fixed code, and the mask does not act on it. The CPU supplies its current mask level. A request is raised only when the winning priority is strictly above that level.

Top module: `grp_prio_intc`

## Requirements
- R1: After reset every priority field is 0, every mask bit is 1, `cpu_req` is 0, and `cpu_code` and `cpu_level` are 0.
- R2: Word addresses 0 to 3 hold fields 4a to 4a+3 in bits [15:0], one nibble per field with the lowest field in bits [3:0]. Bits [31:16] of these words read 0. Address 4 holds fields 16 to 19 in bits [31:16], with field 16 in bits [19:16]. Its bits [15:0] ignore writes and read 0. Read data appears one cycle after `bus_rd`.
- R3: Sources tied to one field (for example sources 2 and 3 to field 2, sources 8 and 9 to field 5, sources 10 to 13 to field 6) all take that field's value as their priority.
- R4: A write to address 5 sets each mask bit whose data bit is 1. A write to address 6 clears each mask bit whose data bit is 1. Data bits of 0 leave the mask unchanged. Reading either address returns the mask.
- R5: A peripheral source whose mask bit is 1, or whose priority field is 0, never wins.
- R6: Among the eligible candidates, the highest priority wins. A tie goes to the lowest index, and the external input ranks ahead of every peripheral source.
- R7: Peripheral source i carries code 0x400 + 0x20*i.
- R8: An external level L in 0 to 14 has priority 15-L and code 0x200 + 0x20*L, and the mask does not act on it. The value 15 means no external request.
- R9: `cpu_req` is 1 only when the winning priority is greater than `cpu_imask`. `cpu_level` then holds that winning priority.
- R10: While `cpu_req` is 0, `cpu_code` and `cpu_level` keep their previous values.
- R11: A change on `src_req`, `ext_lvl` or `cpu_imask` shows at the outputs after one clock edge. A register write shows after two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_req | input | NSRC | Peripheral request levels |
| ext_lvl | input | 4 | Encoded external level, 15 = none |
| cpu_imask | input | 4 | CPU current mask level |
| cpu_req | output | 1 | Request to the CPU |
| cpu_code | output | 12 | Exception code of the presented request |
| cpu_level | output | 4 | Priority of the presented request |

## Verification
A corrupted priority field or mask bit shows as the wrong winner one edge after the affected source becomes active. It also shows on the very next read of its address, so each stimulus row is checked one cycle after it is driven. A faulty tie-break or grouping map shows only when two candidates of equal priority are active together, so the vectors pair such sources on purpose. A broken hold path shows as a code that moves in a cycle where `cpu_req` is low.

// File: rtl/grp_intc_pkg.sv
package grp_intc_pkg;
  localparam int PRIO_W     = 4;
  localparam int CODE_W     = 12;
  localparam int REG_AW     = 3;
  localparam int DATA_W     = 32;
  localparam int NUM_FIELDS = 20;
  localparam int FIELD_IDXW = $clog2(NUM_FIELDS);
  localparam int LSB_W      = $clog2(DATA_W);

  localparam logic [REG_AW-1:0] ADDR_WIDE = 3'd4;
  localparam logic [REG_AW-1:0] ADDR_MSET = 3'd5;
  localparam logic [REG_AW-1:0] ADDR_MCLR = 3'd6;

  localparam logic [CODE_W-1:0] PERIPH_BASE = 12'h400;
  localparam logic [CODE_W-1:0] EXT_BASE    = 12'h200;
  localparam logic [PRIO_W-1:0] EXT_NONE    = 4'hF;

  typedef logic [NUM_FIELDS-1:0][PRIO_W-1:0] prio_arr_t;

  // word address that holds a field
  function automatic logic [REG_AW-1:0] fld_reg(input int f);
    if (f < 16) return REG_AW'(f / 4);
    return ADDR_WIDE;
  endfunction

  // lowest bit of a field inside its word
  function automatic logic [LSB_W-1:0] fld_lsb(input int f);
    if (f < 16) return LSB_W'(4 * (f % 4));
    return LSB_W'(16 + 4 * (f - 16));
  endfunction

  // which priority field a peripheral source draws from
  function automatic logic [FIELD_IDXW-1:0] src_field(input int i);
    case (i)
      0:  return 5'd0;
      1:  return 5'd1;
      2, 3: return 5'd2;
      4, 5, 6: return 5'd3;
      7:  return 5'd4;
      8, 9: return 5'd5;
      10, 11, 12, 13: return 5'd6;
      14: return 5'd7;
      15: return 5'd8;
      16: return 5'd9;
      17: return 5'd10;
      18: return 5'd11;
      19: return 5'd12;
      20: return 5'd13;
      21: return 5'd16;
      22: return 5'd17;
      23: return 5'd18;
      default: return 5'd19;
    endcase
  endfunction
endpackage

// File: rtl/grp_intc_regs.sv
module grp_intc_regs
  import grp_intc_pkg::*;
#(
  parameter int MASK_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [REG_AW-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output prio_arr_t           field_prio,
  output logic [MASK_W-1:0]   mask_q
);
  prio_arr_t          prio_q;
  logic [DATA_W-1:0]  rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q <= '0;
      mask_q <= '1;
      rdata  <= '0;
    end else begin
      if (wr_en) begin
        for (int f = 0; f < NUM_FIELDS; f++) begin
          if (addr == fld_reg(f)) prio_q[f] <= wdata[fld_lsb(f) +: PRIO_W];
        end
        if (addr == ADDR_MSET) mask_q <= mask_q | wdata[MASK_W-1:0];
        if (addr == ADDR_MCLR) mask_q <= mask_q & ~wdata[MASK_W-1:0];
      end
      if (rd_en) rdata <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      if (addr == fld_reg(f)) rd_mux[fld_lsb(f) +: PRIO_W] = prio_q[f];
    end
    if (addr == ADDR_MSET || addr == ADDR_MCLR) rd_mux[MASK_W-1:0] = mask_q;
  end

  assign field_prio = prio_q;
endmodule

// File: rtl/grp_intc_arb.sv
module grp_intc_arb
  import grp_intc_pkg::*;
#(
  parameter int NSRC   = 24,
  parameter int MASK_W = 32
) (
  input  logic [NSRC-1:0]   src_req,
  input  logic [PRIO_W-1:0] ext_lvl,
  input  prio_arr_t         field_prio,
  input  logic [MASK_W-1:0] mask_q,
  output logic              win_valid,
  output logic [PRIO_W-1:0] win_prio,
  output logic [CODE_W-1:0] win_code
);
  localparam int NCAND = NSRC + 1;

  logic [NCAND-1:0][PRIO_W-1:0] cand_prio;
  logic [NCAND-1:0][CODE_W-1:0] cand_code;

  // candidate 0: external encoded level, priority is the inverted level
  assign cand_prio[0] = (ext_lvl != EXT_NONE) ? ~ext_lvl : '0;
  assign cand_code[0] = EXT_BASE + {3'b000, ext_lvl, 5'b00000};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam logic [FIELD_IDXW-1:0] FLD  = src_field(i);
    localparam logic [CODE_W-1:0]     CODE = PERIPH_BASE + CODE_W'(32 * i);
    logic blocked;
    if (i < MASK_W) begin : g_mk
      assign blocked = mask_q[i];
    end else begin : g_nomk
      assign blocked = 1'b0;
    end
    assign cand_prio[i+1] = (src_req[i] && !blocked) ? field_prio[FLD] : '0;
    assign cand_code[i+1] = CODE;
  end

  // strict compare keeps the lowest index on ties
  always_comb begin
    win_prio = '0;
    win_code = '0;
    for (int c = 0; c < NCAND; c++) begin
      if (cand_prio[c] > win_prio) begin
        win_prio = cand_prio[c];
        win_code = cand_code[c];
      end
    end
  end

  assign win_valid = (win_prio != '0);
endmodule

// File: rtl/grp_intc_out.sv
module grp_intc_out
  import grp_intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              win_valid,
  input  logic [PRIO_W-1:0] win_prio,
  input  logic [CODE_W-1:0] win_code,
  input  logic [PRIO_W-1:0] cpu_imask,
  output logic              cpu_req,
  output logic [CODE_W-1:0] cpu_code,
  output logic [PRIO_W-1:0] cpu_level
);
  logic qualify;
  assign qualify = win_valid && (win_prio > cpu_imask);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_req   <= 1'b0;
      cpu_code  <= '0;
      cpu_level <= '0;
    end else begin
      cpu_req <= qualify;
      if (qualify) begin
        cpu_code  <= win_code;
        cpu_level <= win_prio;
      end
    end
  end
endmodule

// File: rtl/grp_prio_intc.sv
module grp_prio_intc
  import grp_intc_pkg::*;
#(
  parameter int NSRC   = 24,
  parameter int MASK_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [REG_AW-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NSRC-1:0]     src_req,
  input  logic [PRIO_W-1:0]   ext_lvl,
  input  logic [PRIO_W-1:0]   cpu_imask,
  output logic                cpu_req,
  output logic [CODE_W-1:0]   cpu_code,
  output logic [PRIO_W-1:0]   cpu_level
);
  prio_arr_t          field_prio;
  logic [MASK_W-1:0]  mask_q;
  logic               win_valid;
  logic [PRIO_W-1:0]  win_prio;
  logic [CODE_W-1:0]  win_code;

  grp_intc_regs #(.MASK_W(MASK_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .field_prio(field_prio), .mask_q(mask_q)
  );

  grp_intc_arb #(.NSRC(NSRC), .MASK_W(MASK_W)) u_arb (
    .src_req(src_req), .ext_lvl(ext_lvl), .field_prio(field_prio), .mask_q(mask_q),
    .win_valid(win_valid), .win_prio(win_prio), .win_code(win_code)
  );

  grp_intc_out u_out (
    .clk(clk), .rst(rst), .win_valid(win_valid), .win_prio(win_prio),
    .win_code(win_code), .cpu_imask(cpu_imask), .cpu_req(cpu_req),
    .cpu_code(cpu_code), .cpu_level(cpu_level)
  );
endmodule

// File: rtl/grp_prio_intc_chk.sv
module grp_prio_intc_chk
  import grp_intc_pkg::*;
#(
  parameter int MASK_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [PRIO_W-1:0] cpu_imask,
  input logic              cpu_req,
  input logic [CODE_W-1:0] cpu_code,
  input logic [PRIO_W-1:0] cpu_level,
  input logic [MASK_W-1:0] mask_q
);
  p_reset_mask_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&mask_q));

  p_mask_set_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_wr) && $past(bus_addr) == ADDR_MSET && !$past(rst))
      |-> ((mask_q & $past(bus_wdata[MASK_W-1:0])) == $past(bus_wdata[MASK_W-1:0])));

  p_mask_clr_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_wr) && $past(bus_addr) == ADDR_MCLR && !$past(rst))
      |-> ((mask_q & $past(bus_wdata[MASK_W-1:0])) == '0));

  p_level_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    cpu_req |-> (cpu_level != '0));

  p_code_grid_r7: assert property (@(posedge clk) disable iff (rst)
    cpu_req |-> (cpu_code[4:0] == 5'd0 && cpu_code >= EXT_BASE));

  p_ext_level_r8: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_code < PERIPH_BASE)
      |-> (cpu_level == ~cpu_code[8:5]));

  p_req_above_imask_r9: assert property (@(posedge clk) disable iff (rst)
    cpu_req |-> (cpu_level > $past(cpu_imask)));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !cpu_req |-> ($stable(cpu_code) && $stable(cpu_level)));
endmodule

bind grp_prio_intc grp_prio_intc_chk #(.MASK_W(MASK_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cpu_imask(cpu_imask), .cpu_req(cpu_req),
  .cpu_code(cpu_code), .cpu_level(cpu_level), .mask_q(mask_q)
);

// File: tb/grp_prio_intc_tb.sv
module grp_prio_intc_tb;
  localparam int NSRC = 24;

  typedef struct packed {
    logic [NSRC-1:0] src;
    logic [3:0]      ext;
    logic [3:0]      imask;
    logic            req;
    logic [11:0]     code;
    logic [3:0]      lvl;
  } vec_t;

  // source priorities after setup: s0=1 s1=2 s2,s3=3 s4..6=4 s7=5 s8,9=A
  // s10..14=0 s15=7 s16..20=0 s21=9 s22=C s23=9
  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{24'h000001, 4'hF, 4'h0, 1'b1, 12'h400, 4'h1},  // R7
    '{24'h000003, 4'hF, 4'h0, 1'b1, 12'h420, 4'h2},  // R6
    '{24'h00000C, 4'hF, 4'h0, 1'b1, 12'h440, 4'h3},  // R3 R6 tie
    '{24'h000008, 4'hF, 4'h0, 1'b1, 12'h460, 4'h3},  // R3
    '{24'h000310, 4'hF, 4'h0, 1'b1, 12'h500, 4'hA},  // R3 R6
    '{24'h000200, 4'hF, 4'h0, 1'b1, 12'h520, 4'hA},  // R3
    '{24'h000400, 4'hF, 4'h0, 1'b0, 12'h000, 4'h0},  // R5 prio 0
    '{24'hA00000, 4'hF, 4'h0, 1'b1, 12'h6A0, 4'h9},  // R6 tie
    '{24'h400000, 4'hF, 4'h0, 1'b1, 12'h6C0, 4'hC},  // R7
    '{24'h400000, 4'hF, 4'hC, 1'b0, 12'h000, 4'h0},  // R9 equal
    '{24'h400000, 4'hF, 4'hB, 1'b1, 12'h6C0, 4'hC},  // R9 above
    '{24'h400000, 4'h0, 4'h0, 1'b1, 12'h200, 4'hF},  // R8
    '{24'h400000, 4'h3, 4'h0, 1'b1, 12'h260, 4'hC},  // R6 ext ahead
    '{24'h000001, 4'hE, 4'h0, 1'b1, 12'h3C0, 4'h1},  // R8 R6
    '{24'h000001, 4'hE, 4'h1, 1'b0, 12'h000, 4'h0},  // R9
    '{24'h000000, 4'hF, 4'h0, 1'b0, 12'h000, 4'h0},  // R10
    '{24'h008000, 4'hF, 4'h0, 1'b1, 12'h5E0, 4'h7},  // R7
    '{24'h008080, 4'hF, 4'h0, 1'b1, 12'h5E0, 4'h7}   // R6
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NSRC-1:0] src_req = '0;
  logic [3:0]  ext_lvl = 4'hF;
  logic [3:0]  cpu_imask = 4'h0;
  logic        cpu_req;
  logic [11:0] cpu_code;
  logic [3:0]  cpu_level;

  int checks = 0;
  int fails  = 0;
  logic [11:0] last_code;
  logic [3:0]  last_lvl;

  always #2.5 clk = ~clk;

  grp_prio_intc #(.NSRC(NSRC)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req(src_req),
    .ext_lvl(ext_lvl), .cpu_imask(cpu_imask), .cpu_req(cpu_req),
    .cpu_code(cpu_code), .cpu_level(cpu_level)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic drive(input logic [NSRC-1:0] s, input logic [3:0] e, input logic [3:0] m);
    @(negedge clk);
    src_req = s; ext_lvl = e; cpu_imask = m;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 req", 32'(cpu_req), 32'd0);
    check("R1 code", 32'(cpu_code), 32'd0);
    check("R1 level", 32'(cpu_level), 32'd0);
    rd(3'd0, d); check("R1 prio reg", d, 32'h0);
    rd(3'd5, d); check("R1 mask", d, 32'hFFFF_FFFF);
    drive(24'h000001, 4'hF, 4'h0);
    check("R1 R5 masked after reset", 32'(cpu_req), 32'd0);

    // setup
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd0, 32'hFFFF_4321);
    wr(3'd1, 32'h0000_00A5);
    wr(3'd2, 32'h0000_0007);
    wr(3'd3, 32'h0000_0000);
    wr(3'd4, 32'h09C9_FFFF);
    rd(3'd0, d); check("R2 narrow reg", d, 32'h0000_4321);
    rd(3'd4, d); check("R2 wide reg", d, 32'h09C9_0000);
    rd(3'd6, d); check("R4 clear all", d, 32'h0);

    last_code = cpu_code;
    last_lvl  = cpu_level;
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].src, TBL[i].ext, TBL[i].imask);
      if (TBL[i].req) begin
        last_code = TBL[i].code;
        last_lvl  = TBL[i].lvl;
      end
      check($sformatf("R6 R9 req row %0d", i), 32'(cpu_req), 32'(TBL[i].req));
      check($sformatf("R7 R8 R10 code row %0d", i), 32'(cpu_code), 32'(last_code));
      check($sformatf("R6 R10 level row %0d", i), 32'(cpu_level), 32'(last_lvl));
    end

    // R4 mask set / clear through separate addresses
    drive(24'h400200, 4'hF, 4'h0);
    check("R4 before mask", 32'(cpu_code), 32'h6C0);
    wr(3'd5, 32'h0040_0000);
    @(negedge clk);
    check("R4 R5 masked s22", 32'(cpu_code), 32'h520);
    rd(3'd6, d); check("R4 mask read", d, 32'h0040_0000);
    wr(3'd5, 32'h0000_0000);
    rd(3'd5, d); check("R4 zero set no effect", d, 32'h0040_0000);
    wr(3'd6, 32'h0000_0000);
    rd(3'd5, d); check("R4 zero clear no effect", d, 32'h0040_0000);
    wr(3'd6, 32'h0040_0000);
    @(negedge clk);
    check("R4 unmask s22", 32'(cpu_code), 32'h6C0);

    // R11 register write latency
    drive(24'h000100, 4'hF, 4'h0);
    check("R11 base", 32'(cpu_level), 32'hA);
    wr(3'd1, 32'h0000_00F5);
    check("R11 one edge old", 32'(cpu_level), 32'hA);
    @(negedge clk);
    check("R11 two edges new", 32'(cpu_level), 32'hF);
    rd(3'd1, d); check("R2 readback", d, 32'h0000_00F5);

    // R8 external not maskable, R5 masked peripheral
    wr(3'd5, 32'hFFFF_FFFF);
    drive(24'h000100, 4'h5, 4'h0);
    check("R8 ext req", 32'(cpu_req), 32'd1);
    check("R8 ext code", 32'(cpu_code), 32'h2A0);
    check("R8 ext level", 32'(cpu_level), 32'hA);
    drive(24'h000100, 4'hF, 4'h0);
    check("R5 masked src", 32'(cpu_req), 32'd0);
    check("R10 hold code", 32'(cpu_code), 32'h2A0);

    finish_run();
  end
endmodule